// File: doc/BRIEF.md
# Garbageless reversible function evaluator

This block evaluates a fixed three-input, two-output Boolean function in a pipeline built only from controlled-swap cells. A controlled-swap cell passes its control bit straight through and exchanges its two data bits when the control is 1. Every cell is therefore its own inverse, and no cell changes the number of ones it carries. The function is y0 = x0 AND x1 and y1 = (x0 AND x1) OR x2.

The pipeline has three phases. A forward network computes y on the argument and scratch wires, which leaves intermediate values on them. A copy layer then writes y and its complement into a result register, whose clean form has zeros in its low half and ones in its high half. Last, the forward cells are applied again in mirrored order, which undoes the forward network. The argument and scratch registers leave the block as they entered, and only the result register has changed. Each layer is registered. A new word is accepted on every cycle, and each word comes out a fixed number of cycles later.

Top module: `rfe_eval`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid is 0 after that edge, and so are out_arg, out_scratch and out_result.
- R2: A word presented with in_valid high appears with out_valid high exactly 5 cycles later (2 forward layers + 1 copy layer + 2 inverse layers). Back-to-back words come out back to back, and a cycle with in_valid low gives a cycle with out_valid low 5 cycles later.
- R3: out_arg equals the in_arg of the same word, for every argument value.
- R4: out_scratch equals the in_scratch of the same word for any scratch value. The clean scratch value is 2'b10 (bit 0 = 0, bit 1 = 1).
- R5: With clean scratch and a clean result input 4'b1100, out_result[1:0] holds y, with bit 0 = x0&x1 and bit 1 = (x0&x1)|x2, where xk = in_arg[k].
- R6: Under the same conditions, out_result[3:2] holds ~y, with bit 2 = ~y0 and bit 3 = ~y1.
- R7: The ones count of {out_result, out_scratch, out_arg} equals the ones count of the matching input word, for any input values.
- R8: With clean scratch and any result input, result bits k and k+2 are exchanged when yk = 1 and left as they are when yk = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_arg | input | 3 | Argument x |
| in_scratch | input | 2 | Scratch constants, clean value 2'b10 |
| in_result | input | 4 | Result register in, clean value 4'b1100 |
| out_valid | output | 1 | Output word is valid |
| out_arg | output | 3 | Argument returned |
| out_scratch | output | 2 | Scratch returned |
| out_result | output | 4 | {~y, y} for clean inputs |

## Verification
Three of the assertions, on restoration, on ones count and on latency, assume nothing about the inputs. They hold for any argument, scratch and result value, because the network composed with its inverse is a set of plain wires and every cell keeps its ones count. The complement assertion assumes that the scratch and result inputs of the word were clean. The checker keeps a record of whether each word was clean and makes the check only when it was. The stimulus covers all eight arguments with clean inputs, runs words with gaps in the valid stream, and feeds dirty result and scratch values only to the checks that do not depend on clean constants.

// File: rtl/rfe_pkg.sv
// Package: sizes and the cell schedule of the reversible evaluator.
// Assumes that cells placed in the same layer touch disjoint wires.
package rfe_pkg;
    localparam int ARG_W  = 3;
    localparam int SCR_W  = 2;
    localparam int RES_N  = 2;
    localparam int NFWD   = 2;
    localparam int RES_W  = 2 * RES_N;
    localparam int WIRES  = ARG_W + SCR_W + RES_W;
    localparam int SCR_LO = ARG_W;
    localparam int RES_LO = ARG_W + SCR_W;
    localparam int NCELL  = 2 * NFWD + RES_N;
    localparam int NLAYER = 2 * NFWD + 1;
    localparam logic [SCR_W-1:0] SCR_CLEAN = 2'b10;
    localparam logic [RES_W-1:0] RES_CLEAN = {{RES_N{1'b1}}, {RES_N{1'b0}}};

    typedef struct packed {
        int ctl;
        int a;
        int b;
        int layer;
    } cell_t;

    // Forward network: wire 3 <- x0&x1, then wire 2 <- (x0&x1)|x2
    function automatic cell_t fwd_cell(input int i);
        cell_t c;
        c.layer = 0;
        case (i)
            0:       begin c.ctl = 0;          c.a = 1; c.b = SCR_LO;     end
            default: begin c.ctl = SCR_LO;     c.a = 2; c.b = SCR_LO + 1; end
        endcase
        return c;
    endfunction

    // Wire that carries result bit k once the forward network has run
    function automatic int y_wire(input int k);
        return (k == 0) ? SCR_LO : 2;
    endfunction

    // Full schedule: forward cells, copy cells, then forward cells mirrored
    function automatic cell_t sched(input int idx);
        cell_t c;
        int k;
        if (idx < NFWD) begin
            c = fwd_cell(idx);
            c.layer = idx;
        end else if (idx < NFWD + RES_N) begin
            k = idx - NFWD;
            c.ctl = y_wire(k);
            c.a = RES_LO + k;
            c.b = RES_LO + RES_N + k;
            c.layer = NFWD;
        end else begin
            k = idx - NFWD - RES_N;
            c = fwd_cell(NFWD - 1 - k);
            c.layer = NFWD + 1 + k;
        end
        return c;
    endfunction
endpackage

// File: rtl/rfe_cswap.sv
// Controlled-swap cell: exchanges the data pair when ctl is 1.
// Combinational and self-inverse; the control is not modified.
module rfe_cswap (
    input  logic ctl,
    input  logic a_in,
    input  logic b_in,
    output logic a_out,
    output logic b_out
);
    // conditional exchange of the two data bits
    always_comb begin
        a_out = ctl ? b_in : a_in;
        b_out = ctl ? a_in : b_in;
    end
endmodule

// File: rtl/rfe_layer.sv
// One registered layer: applies every scheduled cell whose layer equals
// LAYER to the wire vector, then registers it. Assumes disjoint cells.
module rfe_layer #(
    parameter int LAYER = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [rfe_pkg::WIRES-1:0] in_vec,
    output logic                      out_valid,
    output logic [rfe_pkg::WIRES-1:0] out_vec
);
    import rfe_pkg::*;

    logic [WIRES-1:0] chain [NCELL+1];
    assign chain[0] = in_vec;

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        localparam cell_t C = sched(i);
        if (C.layer == LAYER) begin : g_on
            logic ao, bo;
            logic [WIRES-1:0] nxt;
            rfe_cswap u_cs (
                .ctl  (chain[i][C.ctl]),
                .a_in (chain[i][C.a]),
                .b_in (chain[i][C.b]),
                .a_out(ao),
                .b_out(bo)
            );
            // splice the cell outputs into the wire vector
            always_comb begin
                nxt = chain[i];
                nxt[C.a] = ao;
                nxt[C.b] = bo;
            end
            assign chain[i+1] = nxt;
        end else begin : g_off
            assign chain[i+1] = chain[i];
        end
    end

    // layer register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            out_vec   <= chain[NCELL];
        end
    end
endmodule

// File: rtl/rfe_eval.sv
// Top: compute, copy and uncompute layers in series, NLAYER cycles latency.
// Assumes the caller supplies clean scratch and result words when it wants y.
module rfe_eval (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [rfe_pkg::ARG_W-1:0]         in_arg,
    input  logic [rfe_pkg::SCR_W-1:0]         in_scratch,
    input  logic [rfe_pkg::RES_W-1:0]         in_result,
    output logic                              out_valid,
    output logic [rfe_pkg::ARG_W-1:0]         out_arg,
    output logic [rfe_pkg::SCR_W-1:0]         out_scratch,
    output logic [rfe_pkg::RES_W-1:0]         out_result
);
    import rfe_pkg::*;

    logic [WIRES-1:0] vec [NLAYER+1];
    logic             vld [NLAYER+1];

    assign vec[0] = {in_result, in_scratch, in_arg};
    assign vld[0] = in_valid;

    for (genvar l = 0; l < NLAYER; l++) begin : g_layer
        rfe_layer #(.LAYER(l)) u_layer (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (vld[l]),
            .in_vec   (vec[l]),
            .out_valid(vld[l+1]),
            .out_vec  (vec[l+1])
        );
    end

    assign out_valid   = vld[NLAYER];
    assign out_arg     = vec[NLAYER][ARG_W-1:0];
    assign out_scratch = vec[NLAYER][SCR_LO +: SCR_W];
    assign out_result  = vec[NLAYER][RES_LO +: RES_W];
endmodule

// File: rtl/rfe_checker.sv
// Checker for rfe_eval: keeps its own record of each word's inputs and
// relates them to the outputs NLAYER cycles later.
module rfe_checker (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [rfe_pkg::ARG_W-1:0] in_arg,
    input logic [rfe_pkg::SCR_W-1:0] in_scratch,
    input logic [rfe_pkg::RES_W-1:0] in_result,
    input logic                      out_valid,
    input logic [rfe_pkg::ARG_W-1:0] out_arg,
    input logic [rfe_pkg::SCR_W-1:0] out_scratch,
    input logic [rfe_pkg::RES_W-1:0] out_result
);
    import rfe_pkg::*;

    logic             sv [NLAYER];
    logic [WIRES-1:0] sw [NLAYER];
    logic             sc [NLAYER];

    // record of the words in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLAYER; i++) begin
                sv[i] <= 1'b0;
                sw[i] <= '0;
                sc[i] <= 1'b0;
            end
        end else begin
            sv[0] <= in_valid;
            sw[0] <= {in_result, in_scratch, in_arg};
            sc[0] <= (in_scratch == SCR_CLEAN) && (in_result == RES_CLEAN);
            for (int i = 1; i < NLAYER; i++) begin
                sv[i] <= sv[i-1];
                sw[i] <= sw[i-1];
                sc[i] <= sc[i-1];
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == sv[NLAYER-1]);

    assert_arg_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_arg == sw[NLAYER-1][ARG_W-1:0]);

    assert_scratch_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_scratch == sw[NLAYER-1][SCR_LO +: SCR_W]);

    assert_complement_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sc[NLAYER-1]) |->
            out_result[RES_W-1:RES_N] == ~out_result[RES_N-1:0]);

    assert_ones_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({out_result, out_scratch, out_arg})
                      == $countones(sw[NLAYER-1]));
endmodule

bind rfe_eval rfe_checker i_rfe_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_arg     (in_arg),
    .in_scratch (in_scratch),
    .in_result  (in_result),
    .out_valid  (out_valid),
    .out_arg    (out_arg),
    .out_scratch(out_scratch),
    .out_result (out_result)
);

// File: tb/test_rfe_eval.sv
`timescale 1ns/1ps
module test_rfe_eval;
    localparam int LAT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_arg = '0;
    logic [1:0] in_scratch = '0;
    logic [3:0] in_result = '0;
    logic       out_valid;
    logic [2:0] out_arg;
    logic [1:0] out_scratch;
    logic [3:0] out_result;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic       s_vld [16];
    logic [2:0] s_arg [16];
    logic [1:0] s_scr [16];
    logic [3:0] s_res [16];

    always #2.5 clk = ~clk;

    rfe_eval i_rfe_eval (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_arg(in_arg),
        .in_scratch(in_scratch), .in_result(in_result), .out_valid(out_valid),
        .out_arg(out_arg), .out_scratch(out_scratch), .out_result(out_result)
    );

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] f_model(input logic [2:0] x);
        logic a;
        a = x[0] & x[1];
        return {a | x[2], a};
    endfunction

    // result pair k exchanged when yk is 1
    function automatic logic [3:0] res_model(input logic [2:0] x, input logic [3:0] r);
        logic [1:0] y;
        logic [3:0] o;
        y = f_model(x);
        o = r;
        for (int k = 0; k < 2; k++)
            if (y[k]) begin o[k] = r[k+2]; o[k+2] = r[k]; end
        return o;
    endfunction

    // drive m words from the s_* arrays and check each LAT cycles later
    task automatic run(input int m, input bit chk_res, input bit dirty_res);
        for (int i = 0; i < m + LAT; i++) begin
            @(negedge clk);
            if (i >= LAT) begin
                int j;
                logic [3:0] er;
                j = i - LAT;
                chk("R2 out_valid", int'(out_valid), int'(s_vld[j]));
                if (s_vld[j]) begin
                    chk("R3 arg", int'(out_arg), int'(s_arg[j]));
                    chk("R4 scratch", int'(out_scratch), int'(s_scr[j]));
                    chk("R7 ones", $countones({out_result, out_scratch, out_arg}),
                        $countones({s_res[j], s_scr[j], s_arg[j]}));
                    if (chk_res) begin
                        er = res_model(s_arg[j], s_res[j]);
                        if (dirty_res)
                            chk("R8 pair swap", int'(out_result), int'(er));
                        else begin
                            chk("R5 y", int'(out_result[1:0]), int'(er[1:0]));
                            chk("R6 ~y", int'(out_result[3:2]), int'(er[3:2]));
                        end
                    end
                end
            end
            if (i < m) begin
                in_valid = s_vld[i]; in_arg = s_arg[i];
                in_scratch = s_scr[i]; in_result = s_res[i];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 outputs", int'({out_result, out_scratch, out_arg}), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_all_args();
        for (int i = 0; i < 8; i++) begin
            s_vld[i] = 1'b1; s_arg[i] = 3'(i); s_scr[i] = 2'b10; s_res[i] = 4'b1100;
        end
        run(8, 1'b1, 1'b0);
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 10; i++) begin
            s_vld[i] = (i % 3) != 1; s_arg[i] = 3'(7 - (i % 8));
            s_scr[i] = 2'b10; s_res[i] = 4'b1100;
        end
        run(10, 1'b1, 1'b0);
    endtask

    task automatic t_dirty_result();
        for (int i = 0; i < 8; i++) begin
            s_vld[i] = 1'b1; s_arg[i] = 3'(i); s_scr[i] = 2'b10;
            s_res[i] = 4'(4'b0110 ^ i[3:0] ^ {i[1:0], 2'b00});
        end
        run(8, 1'b1, 1'b1);
    endtask

    task automatic t_dirty_scratch();
        for (int i = 0; i < 8; i++) begin
            s_vld[i] = 1'b1; s_arg[i] = 3'(i); s_scr[i] = 2'(i + 1);
            s_res[i] = 4'(i * 5);
        end
        run(8, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_all_args();
        t_gaps();
        t_dirty_result();
        t_dirty_scratch();
        t_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule